// File: doc/BRIEF.md
# FEC Receive Control and Status Register Bank

This block is the software-visible register bank for the receive half of a four-lane Reed-Solomon forward error correction sublayer. It sits on a simple word-addressed bus. A write takes effect in the cycle it is presented. A read returns its data on `rdata` one cycle after `rd_en` is high. The decoder, the marker-lock and deskew machines, and the correction datapath live elsewhere. They connect to this bank only through level inputs (lock, alignment, lane numbers), one-cycle event strobes (corrected and uncorrected codewords, restart acknowledge) and two control levels (decoder bypass and restart request).

The bank returns fixed identification words and offers a scratch word. It has a control word that holds the bypass level and a restart request, which stays pending until the datapath acknowledges it. It packs live lane-lock, alignment and lane-number status into one word. It keeps two saturating event counters that return to zero when they are read. The counter width is a parameter (default 32), and read data zero-extends each counter to 32 bits.

Top module: `fec_rx_csr`

## Requirements
- R1: Reads of 0xD00, 0xD02, 0xD03 and 0xD04 return 0x05152015, 0x436F5258, 0x52534645 and 0x31303067. Writes to these addresses change nothing.
- R2: 0xD01 is a 32-bit read/write scratch word that is zero after reset.
- R3: In the control word at 0xD05, bit 0 holds the decoder bypass level and drives `bypass_decoder`. Bits 3:1 read as zero. The word is zero after reset.
- R4: Writing 1 to bit 4 of 0xD05 sets a pending restart. Bit 4 reads back as 1 and `restart_req` is high while the restart is pending. A `restart_ack` pulse clears it. If a set and an acknowledge arrive in the same cycle, the set wins. Writing 0 to bit 4 does not clear a pending restart.
- R5: A read of 0xD06 returns the live status: bits 3:0 are per-lane lock, bit 4 is the all-lanes-aligned flag, bits 7:5 are zero, bits 9:8 to 15:14 hold the 2-bit lane number of physical lanes 0 to 3, and bits 31:16 are zero.
- R6: A lane's 2-bit lane-number field reads as zero whenever that lane's lock bit is 0.
- R7: 0xD07 counts `corr_cw_inc` strobes and 0xD08 counts `uncorr_cw_inc` strobes, one per high cycle. Both counters are zero after reset.
- R8: Each counter stops at its all-ones value and stays there.
- R9: A read of a counter returns the count before the read and leaves the counter at zero.
- R10: If a strobe arrives in the same cycle as a read of its counter, the read returns the old value and the counter continues from 1.
- R11: Reads of unmapped addresses return zero. Writes to unmapped addresses change no register and no output.
- R12: `rdata` carries the read value in the cycle after `rd_en`, and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| amps_lock | input | 4 | Per-lane alignment-marker lock |
| align_done | input | 1 | All lanes aligned and deskewed |
| fec_lane_map | input | 8 | 2-bit lane number per physical lane, lane 0 in bits 1:0 |
| corr_cw_inc | input | 1 | One corrected codeword |
| uncorr_cw_inc | input | 1 | One uncorrected codeword |
| restart_ack | input | 1 | One-cycle pulse: restart has taken effect |
| bypass_decoder | output | 1 | Decoder bypass level |
| restart_req | output | 1 | Pending restart request level |

## Verification
The assertions assume that bus inputs are never X after reset, and that `restart_ack` is a single-cycle pulse. The saturation property also assumes that a counter read and a strobe are the only events that move that counter. The bench drives every input from known values after reset and makes `restart_ack` high for one cycle at a time. It builds the design with an 8-bit counter width, so that a directed run of a few hundred strobes reaches the saturation point. Random traffic then mixes reads, writes, strobes and status changes against a bench model.

// File: rtl/fec_rx_csr_pkg.sv
package fec_rx_csr_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int NUM_LANES = 4;
    localparam int LANE_ID_W = 2;
    localparam int LANE_FLD_LSB = 8;

    localparam logic [ADDR_W-1:0] A_REV     = 12'hD00;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 12'hD01;
    localparam logic [ADDR_W-1:0] A_ID_LO   = 12'hD02;
    localparam logic [ADDR_W-1:0] A_ID_MID  = 12'hD03;
    localparam logic [ADDR_W-1:0] A_ID_HI   = 12'hD04;
    localparam logic [ADDR_W-1:0] A_CTRL    = 12'hD05;
    localparam logic [ADDR_W-1:0] A_STATUS  = 12'hD06;
    localparam logic [ADDR_W-1:0] A_CORR    = 12'hD07;
    localparam logic [ADDR_W-1:0] A_UNCORR  = 12'hD08;

    localparam logic [DATA_W-1:0] REV_WORD    = 32'h0515_2015;
    localparam logic [DATA_W-1:0] ID_LO_WORD  = 32'h436F_5258;
    localparam logic [DATA_W-1:0] ID_MID_WORD = 32'h5253_4645;
    localparam logic [DATA_W-1:0] ID_HI_WORD  = 32'h3130_3067;

    localparam int CTRL_BYPASS_BIT  = 0;
    localparam int CTRL_RESTART_BIT = 4;
    localparam int STAT_ALIGN_BIT   = 4;

    typedef struct packed {
        logic restart;
        logic bypass;
    } ctrl_t;

    typedef struct packed {
        logic [NUM_LANES-1:0]           lock;
        logic                           aligned;
        logic [NUM_LANES*LANE_ID_W-1:0] lanes;
    } status_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_BYPASS_BIT]  = c.bypass;
        w[CTRL_RESTART_BIT] = c.restart;
        return w;
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a >= A_REV) && (a <= A_UNCORR);
    endfunction

endpackage

// File: rtl/fec_rx_sat_cnt.sv
module fec_rx_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? W'(1) : '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + W'(1);
        end
    end

    assert_hold_at_max_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> cnt == '0);

    assert_read_with_event_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && inc) |=> cnt == W'(1));

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/fec_rx_ctrl_reg.sv
module fec_rx_ctrl_reg
    import fec_rx_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  logic  wbit_bypass,
    input  logic  wbit_restart,
    input  logic  restart_ack,
    output ctrl_t ctrl
);
    logic set_restart;
    assign set_restart = wr_ctrl && wbit_restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl)
                ctrl.bypass <= wbit_bypass;
            if (set_restart)
                ctrl.restart <= 1'b1;
            else if (restart_ack)
                ctrl.restart <= 1'b0;
        end
    end

    assert_restart_pending_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.restart && !restart_ack) |=> ctrl.restart);

    assert_restart_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (restart_ack && !wr_ctrl) |=> !ctrl.restart);

    assert_bypass_only_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl.bypass));

endmodule

// File: rtl/fec_rx_status_pack.sv
module fec_rx_status_pack
    import fec_rx_csr_pkg::*;
(
    input  logic [NUM_LANES-1:0]           lock,
    input  logic                           aligned,
    input  logic [NUM_LANES*LANE_ID_W-1:0] lane_map,
    output logic [DATA_W-1:0]              word
);
    status_t st;

    assign st.lock    = lock;
    assign st.aligned = aligned;

    genvar g;
    generate
        for (g = 0; g < NUM_LANES; g++) begin : g_lane
            assign st.lanes[g*LANE_ID_W +: LANE_ID_W] =
                lock[g] ? lane_map[g*LANE_ID_W +: LANE_ID_W] : '0;
        end
    endgenerate

    always_comb begin
        word = '0;
        word[NUM_LANES-1:0] = st.lock;
        word[STAT_ALIGN_BIT] = st.aligned;
        word[LANE_FLD_LSB +: NUM_LANES*LANE_ID_W] = st.lanes;
    end

endmodule

// File: rtl/fec_rx_csr.sv
module fec_rx_csr
    import fec_rx_csr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic [3:0]  amps_lock,
    input  logic        align_done,
    input  logic [7:0]  fec_lane_map,
    input  logic        corr_cw_inc,
    input  logic        uncorr_cw_inc,
    input  logic        restart_ack,
    output logic        bypass_decoder,
    output logic        restart_req
);
    localparam int NUM_CNT = 2;

    logic [DATA_W-1:0] scratch_q;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] rd_value;

    logic [NUM_CNT-1:0]       cnt_inc;
    logic [NUM_CNT-1:0]       cnt_clr;
    logic [ADDR_W-1:0]        cnt_addr [NUM_CNT];
    logic [CNT_W-1:0]         cnt_val  [NUM_CNT];

    assign cnt_inc     = {uncorr_cw_inc, corr_cw_inc};
    assign cnt_addr[0] = A_CORR;
    assign cnt_addr[1] = A_UNCORR;

    always_ff @(posedge clk) begin
        if (rst)
            scratch_q <= '0;
        else if (wr_en && addr == A_SCRATCH)
            scratch_q <= wdata;
    end

    fec_rx_ctrl_reg u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_en && addr == A_CTRL),
        .wbit_bypass  (wdata[CTRL_BYPASS_BIT]),
        .wbit_restart (wdata[CTRL_RESTART_BIT]),
        .restart_ack  (restart_ack),
        .ctrl         (ctrl)
    );

    assign bypass_decoder = ctrl.bypass;
    assign restart_req    = ctrl.restart;

    fec_rx_status_pack u_status (
        .lock     (amps_lock),
        .aligned  (align_done),
        .lane_map (fec_lane_map),
        .word     (status_word)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CNT; g++) begin : g_cnt
            assign cnt_clr[g] = rd_en && addr == cnt_addr[g];
            fec_rx_sat_cnt #(.W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .inc (cnt_inc[g]),
                .clr (cnt_clr[g]),
                .cnt (cnt_val[g])
            );
        end
    endgenerate

    always_comb begin
        unique case (addr)
            A_REV:     rd_value = REV_WORD;
            A_SCRATCH: rd_value = scratch_q;
            A_ID_LO:   rd_value = ID_LO_WORD;
            A_ID_MID:  rd_value = ID_MID_WORD;
            A_ID_HI:   rd_value = ID_HI_WORD;
            A_CTRL:    rd_value = ctrl_word(ctrl);
            A_STATUS:  rd_value = status_word;
            A_CORR:    rd_value = DATA_W'(cnt_val[0]);
            A_UNCORR:  rd_value = DATA_W'(cnt_val[1]);
            default:   rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_value : '0;
    end

    assert_idle_bus_R12: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !is_mapped(addr)) |=> rdata == '0);

    assert_rev_word_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_REV) |=> rdata == 32'h0515_2015);

    assert_lane0_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_STATUS && !amps_lock[0]) |=> rdata[9:8] == 2'b00);

    assert_scratch_kept_R2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_SCRATCH) |=> $stable(scratch_q));

endmodule

// File: tb/fec_rx_csr_test.sv
module fec_rx_csr_test;
    localparam int CW = 8;
    localparam logic [CW-1:0] CMAX = '1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  amps_lock = '0;
    logic        align_done = 1'b0;
    logic [7:0]  fec_lane_map = '0;
    logic        corr_cw_inc = 1'b0, uncorr_cw_inc = 1'b0, restart_ack = 1'b0;
    logic        bypass_decoder, restart_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0]   m_scratch;
    logic          m_bypass, m_restart;
    logic [CW-1:0] m_cnt [2];

    always #5 clk = ~clk;

    fec_rx_csr #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .amps_lock(amps_lock),
        .align_done(align_done), .fec_lane_map(fec_lane_map),
        .corr_cw_inc(corr_cw_inc), .uncorr_cw_inc(uncorr_cw_inc),
        .restart_ack(restart_ack), .bypass_decoder(bypass_decoder),
        .restart_req(restart_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] status_exp(input logic [3:0] lk, input logic al,
                                               input logic [7:0] lm);
        logic [31:0] w;
        w = '0;
        w[3:0] = lk;
        w[4] = al;
        for (int i = 0; i < 4; i++)
            w[8 + 2*i +: 2] = lk[i] ? lm[2*i +: 2] : 2'b00;
        return w;
    endfunction

    function automatic logic [31:0] read_exp(input logic [11:0] a);
        case (a)
            12'hD00: return 32'h0515_2015;
            12'hD01: return m_scratch;
            12'hD02: return 32'h436F_5258;
            12'hD03: return 32'h5253_4645;
            12'hD04: return 32'h3130_3067;
            12'hD05: return {27'd0, m_restart, 3'b000, m_bypass};
            12'hD06: return status_exp(amps_lock, align_done, fec_lane_map);
            12'hD07: return {24'd0, m_cnt[0]};
            12'hD08: return {24'd0, m_cnt[1]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_update();
        logic [1:0] inc;
        inc = {uncorr_cw_inc, corr_cw_inc};
        if (wr_en && addr == 12'hD01) m_scratch = wdata;
        if (wr_en && addr == 12'hD05) m_bypass = wdata[0];
        if (wr_en && addr == 12'hD05 && wdata[4]) m_restart = 1'b1;
        else if (restart_ack) m_restart = 1'b0;
        for (int k = 0; k < 2; k++) begin
            if (rd_en && addr == (12'hD07 + 12'(k)))
                m_cnt[k] = inc[k] ? CW'(1) : '0;
            else if (inc[k] && m_cnt[k] != CMAX)
                m_cnt[k] = m_cnt[k] + CW'(1);
        end
    endtask

    // One bus cycle: inputs set at the falling edge, results checked 2 ns after the rising edge.
    task automatic cyc(input string tag, input logic w, input logic r, input logic [11:0] a,
                       input logic [31:0] d, input logic ci, input logic ui, input logic ak);
        logic [31:0] exp_rd;
        wr_en = w; rd_en = r; addr = a; wdata = d;
        corr_cw_inc = ci; uncorr_cw_inc = ui; restart_ack = ak;
        exp_rd = r ? read_exp(a) : 32'd0;
        model_update();
        @(posedge clk);
        #2;
        check(tag, rdata, exp_rd);
        check({tag, " R3 bypass"}, {31'd0, bypass_decoder}, {31'd0, m_bypass});
        check({tag, " R4 restart_req"}, {31'd0, restart_req}, {31'd0, m_restart});
        @(negedge clk);
    endtask

    task automatic rd(input string tag, input logic [11:0] a);
        cyc(tag, 1'b0, 1'b1, a, 32'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
        cyc(tag, 1'b1, 1'b0, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = $urandom(32'h5EED_0042);
        m_scratch = '0; m_bypass = 1'b0; m_restart = 1'b0;
        m_cnt[0] = '0; m_cnt[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R12 idle rdata after reset", rdata, 32'd0);
        rd("R2 scratch reset", 12'hD01);
        rd("R3 ctrl reset", 12'hD05);
        rd("R7 corr reset", 12'hD07);
        rd("R7 uncorr reset", 12'hD08);

        // R1 identification words, and writes to them are ignored
        rd("R1 rev", 12'hD00);
        rd("R1 id lo", 12'hD02);
        rd("R1 id mid", 12'hD03);
        rd("R1 id hi", 12'hD04);
        wr("R1 write rev", 12'hD00, 32'hFFFF_FFFF);
        wr("R1 write id", 12'hD03, 32'h0);
        rd("R1 rev after write", 12'hD00);
        rd("R1 id mid after write", 12'hD03);

        // R2 scratch
        wr("R2 scratch write", 12'hD01, 32'hA5A5_5A5A);
        rd("R2 scratch read", 12'hD01);
        wr("R2 scratch write2", 12'hD01, 32'h1234_5678);
        rd("R2 scratch read2", 12'hD01);

        // R3 bypass and reserved bits
        wr("R3 bypass set with reserved", 12'hD05, 32'h0000_000F);
        rd("R3 ctrl read", 12'hD05);
        wr("R3 bypass clear", 12'hD05, 32'h0);
        rd("R3 ctrl read2", 12'hD05);

        // R4 restart handshake
        wr("R4 restart set", 12'hD05, 32'h10);
        rd("R4 restart pending", 12'hD05);
        wr("R4 write zero no effect", 12'hD05, 32'h0);
        rd("R4 still pending", 12'hD05);
        cyc("R4 ack", 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0, 1'b1);
        rd("R4 cleared", 12'hD05);
        cyc("R4 set wins over ack", 1'b1, 1'b0, 12'hD05, 32'h11, 1'b0, 1'b0, 1'b1);
        rd("R4 set wins read", 12'hD05);
        cyc("R4 ack2", 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b0, 1'b1);

        // R5 / R6 status packing
        amps_lock = 4'b1111; align_done = 1'b1; fec_lane_map = 8'b00_01_10_11;
        rd("R5 status all locked", 12'hD06);
        amps_lock = 4'b0101; align_done = 1'b0; fec_lane_map = 8'hFF;
        rd("R6 status partial lock", 12'hD06);
        amps_lock = 4'b0000; fec_lane_map = 8'hE4;
        rd("R6 status no lock", 12'hD06);

        // R11 unmapped
        rd("R11 unmapped read", 12'hD09);
        rd("R11 unmapped read low", 12'h0CFF);
        wr("R11 unmapped write", 12'hD0A, 32'hFFFF_FFFF);
        rd("R11 scratch untouched", 12'hD01);
        rd("R11 ctrl untouched", 12'hD05);

        // R7 counting, R9 clear on read
        repeat (5) cyc("R7 corr inc", 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        repeat (3) cyc("R7 uncorr inc", 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b1, 1'b0);
        rd("R9 corr read 5", 12'hD07);
        rd("R9 corr after read", 12'hD07);
        rd("R9 uncorr read 3", 12'hD08);

        // R8 saturation
        for (int i = 0; i < 300; i++)
            cyc("R8 fill", 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b1, 1'b0);
        cyc("R8 hold", 1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b0, 1'b0);
        // R10 read coinciding with increment
        cyc("R10 corr read with inc", 1'b0, 1'b1, 12'hD07, 32'h0, 1'b1, 1'b0, 1'b0);
        rd("R10 corr restarts at 1", 12'hD07);
        rd("R8 uncorr saturated", 12'hD08);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] a;
            logic w, r;
            a = 12'hD00 + 12'($urandom_range(0, 10));
            if ($urandom_range(0, 15) == 0) a = 12'($urandom);
            w = ($urandom_range(0, 3) == 0);
            r = ($urandom_range(0, 1) == 0);
            if (($urandom_range(0, 7)) == 0) begin
                amps_lock = 4'($urandom);
                align_done = 1'($urandom);
                fec_lane_map = 8'($urandom);
            end
            cyc("R12 random", w, r, a, $urandom, 1'($urandom), 1'($urandom),
                ($urandom_range(0, 5) == 0));
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule